// File: doc/BRIEF.md
# Descending Stack Push/Pop Sequencer

This block owns a stack pointer register and drives a single-word synchronous memory port to carry out push and pop operations on a stack that grows toward lower addresses. The pointer always names the slot that holds the current top element. A push takes a data word, moves the pointer down by one slot, and then stores the word at the new pointer. A pop reads the word the pointer names, moves the pointer up by one slot, and then presents the word on its output. A request is taken only while the engine is idle. Each completed operation ends with a one-cycle done pulse.

A slot holds one 64-bit word, which is 8 bytes. The pointer must therefore be a multiple of 8 when an operation starts. If it is not, the engine flags an alignment error and does nothing else. After reset the pointer holds a top address set by a parameter. Memory reads return their data in the cycle after the request.

Top module: `stack_engine`

## Requirements
- R1: After reset, sp_out equals the parameter INIT_TOP, and busy, done and align_err are all 0.
- R2: A push moves sp_out down by 8 and only then issues one write (mem_req=1, mem_we=1). The write goes to the new pointer and carries the pushed data.
- R3: A pop issues one read (mem_req=1, mem_we=0) at the current pointer. It then moves sp_out up by 8 and drives the word it read on pop_data, which holds that value until the next pop finishes.
- R4: done is a one-cycle pulse. For both push and pop it is high in the third cycle after the clock edge that accepts the request. For a pop this is the cycle after the read data returns.
- R5: Pops return words in reverse order of their pushes, each pop giving back the most recent word that has not yet been popped.
- R6: If sp_out[2:0] is not 0 when a push or pop is requested, align_err pulses high for one cycle. In that case no memory request is made, sp_out does not change and done does not rise.
- R7: While busy is 1, push_req and pop_req are ignored. No extra operation, memory access or done pulse follows from them.
- R8: If push_req and pop_req are both high at the edge that accepts a request, the push is performed and the pop is dropped.
- R9: Every memory request uses an address that is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request a push of push_data |
| pop_req | input | 1 | Request a pop |
| push_data | input | DW | Word to push |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Misaligned pointer at request, one-cycle pulse |
| pop_data | output | DW | Word returned by the last pop |
| sp_out | output | AW | Current stack pointer |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |

## Verification
A wrong pointer shows up on sp_out at the done pulse of the same operation. It also appears as a write or read address that is off by one slot. A mix-up between read and write ordering shows up as a word from the wrong slot, which the LIFO sequence exposes on the next pop. A wrong sequencer state shows up as done landing in the wrong cycle or as a memory access that should not exist. Both are seen within three cycles of the request.

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter logic [AW-1:0] INIT_TOP = 64'h200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] push_data,
  output logic          busy,
  output logic          done,
  output logic          align_err,
  output logic [DW-1:0] pop_data,
  output logic [AW-1:0] sp_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int SLOT_BYTES = DW / 8;
  localparam int LOW_BITS = $clog2(SLOT_BYTES);
  localparam logic [AW-1:0] STEP = AW'(SLOT_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_WR, S_RD, S_INC, S_FIN} state_t;

  state_t        state;
  logic [AW-1:0] sp;
  logic [DW-1:0] hold;
  logic          misaligned;

  assign misaligned = |sp[LOW_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp        <= INIT_TOP;
      hold      <= '0;
      pop_data  <= '0;
      align_err <= 1'b0;
    end else begin
      align_err <= 1'b0;
      case (state)
        S_IDLE: if (push_req || pop_req) begin
          if (misaligned) align_err <= 1'b1;
          else if (push_req) begin
            hold  <= push_data;
            state <= S_DEC;
          end else state <= S_RD;
        end
        S_DEC: begin
          sp    <= sp - STEP;
          state <= S_WR;
        end
        S_WR: state <= S_FIN;
        S_RD: state <= S_INC;
        S_INC: begin
          pop_data <= mem_rdata;
          sp       <= sp + STEP;
          state    <= S_FIN;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign mem_req   = (state == S_WR) || (state == S_RD);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = sp;
  assign mem_wdata = hold;
  assign sp_out    = sp;

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR) |-> (sp == $past(sp) - STEP));

  p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIN && $past(state) == S_INC) |-> (sp == $past(sp) + STEP));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!busy && !mem_req && $stable(sp)));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_addr_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[LOW_BITS-1:0] == '0));
endmodule

// File: tb/stack_engine_tb.sv
module stack_engine_tb;
  localparam logic [63:0] TOP = 64'h200;
  localparam logic [63:0] ODD_TOP = 64'h204;
  localparam int NV = 8;
  localparam logic [1:0] OP_PUSH = 2'd1;
  localparam logic [1:0] OP_POP = 2'd2;
  localparam logic [1:0] V_OP [NV] = '{OP_PUSH, OP_PUSH, OP_PUSH, OP_POP,
                                      OP_POP, OP_PUSH, OP_POP, OP_POP};
  localparam logic [63:0] V_DATA [NV] = '{64'hAAAA_0000_1111_2222, 64'hBBBB_3333_4444_5555,
                                         64'hCCCC_6666_7777_8888, 64'h0,
                                         64'h0, 64'hDDDD_9999_0000_EEEE, 64'h0, 64'h0};
  localparam logic [63:0] V_SP [NV] = '{64'h1F8, 64'h1F0, 64'h1E8, 64'h1F0,
                                       64'h1F8, 64'h1F0, 64'h1F8, 64'h200};
  localparam logic [63:0] V_POP [NV] = '{64'h0, 64'h0, 64'h0, 64'hCCCC_6666_7777_8888,
                                        64'hBBBB_3333_4444_5555, 64'h0,
                                        64'hDDDD_9999_0000_EEEE, 64'hAAAA_0000_1111_2222};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 1'b0, pop_req = 1'b0;
  logic [63:0] push_data = '0;
  logic busy, done, align_err, mem_req, mem_we;
  logic [63:0] pop_data, sp_out, mem_addr, mem_wdata;
  logic [63:0] mem_rdata = '0;

  logic o_push = 1'b0, o_pop = 1'b0;
  logic o_busy, o_done, o_err, o_req, o_we;
  logic [63:0] o_pop_data, o_sp, o_addr, o_wdata;

  int errors = 0, checks = 0;
  logic [63:0] mem [0:63];
  logic [63:0] last_addr = '0;
  logic last_we = 1'b0;
  int req_count = 0, done_count = 0, o_req_count = 0, o_done_count = 0;

  always #4 clk = ~clk;

  stack_engine #(.AW(64), .DW(64), .INIT_TOP(TOP)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .busy(busy), .done(done), .align_err(align_err),
    .pop_data(pop_data), .sp_out(sp_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  stack_engine #(.AW(64), .DW(64), .INIT_TOP(ODD_TOP)) u_odd (
    .clk(clk), .rst_n(rst_n), .push_req(o_push), .pop_req(o_pop),
    .push_data(64'h1234), .busy(o_busy), .done(o_done), .align_err(o_err),
    .pop_data(o_pop_data), .sp_out(o_sp), .mem_req(o_req), .mem_we(o_we),
    .mem_addr(o_addr), .mem_wdata(o_wdata), .mem_rdata(64'h0));

  always_ff @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[8:3]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[8:3]];
      last_addr <= mem_addr;
      last_we   <= mem_we;
      req_count <= req_count + 1;
    end
    if (done) done_count <= done_count + 1;
    if (o_req) o_req_count <= o_req_count + 1;
    if (o_done) o_done_count <= o_done_count + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [63:0] d, output int lat);
    @(negedge clk);
    push_req  = (op == OP_PUSH);
    pop_req   = (op == OP_POP);
    push_data = d;
    @(negedge clk);
    push_req = 1'b0;
    pop_req  = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat, rc, dc;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp after reset", sp_out, TOP);
    chk("R1 busy/done/err after reset", {61'd0, busy, done, align_err}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      run_op(V_OP[v], V_DATA[v], lat);
      chk("R4 done latency", 64'(lat), 64'd3);
      chk("R2/R3 sp after op", sp_out, V_SP[v]);
      if (V_OP[v] == OP_PUSH) begin
        chk("R2 write address is new sp", last_addr, V_SP[v]);
        chk("R2 write strobe", {63'd0, last_we}, 64'd1);
        chk("R2 stored word", mem[V_SP[v][8:3]], V_DATA[v]);
      end else begin
        chk("R3 read address is old sp", last_addr, V_SP[v] - 64'd8);
        chk("R5 pop returns last pushed", pop_data, V_POP[v]);
      end
      @(negedge clk);
      chk("R4 done is one cycle", {63'd0, done}, 64'd0);
    end

    rc = req_count;
    dc = done_count;
    @(negedge clk);
    push_req = 1'b1; push_data = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk);
    push_req = 1'b0;
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    push_req = 1'b1; push_data = 64'h77;
    @(negedge clk);
    push_req = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 sp after ignored requests", sp_out, 64'h1F8);
    chk("R7 one memory access only", 64'(req_count - rc), 64'd1);
    chk("R7 one done only", 64'(done_count - dc), 64'd1);
    chk("R7 word stored unchanged", mem[6'h3F], 64'h5555_AAAA_5555_AAAA);

    rc = req_count;
    @(negedge clk);
    push_req = 1'b1; pop_req = 1'b1; push_data = 64'h0BAD_F00D;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 push wins sp", sp_out, 64'h1F0);
    chk("R8 push wins write", {63'd0, last_we}, 64'd1);
    chk("R8 push wins word", mem[6'h3E], 64'h0BAD_F00D);
    run_op(OP_POP, 64'h0, lat);
    chk("R5 pop after priority push", pop_data, 64'h0BAD_F00D);
    run_op(OP_POP, 64'h0, lat);
    chk("R5 pop earlier word", pop_data, 64'h5555_AAAA_5555_AAAA);
    chk("R3 sp back to top", sp_out, TOP);

    @(negedge clk);
    o_push = 1'b1;
    @(negedge clk);
    o_push = 1'b0;
    chk("R6 push err pulse", {62'd0, o_err, o_busy}, 64'd2);
    @(negedge clk);
    chk("R6 err drops", {63'd0, o_err}, 64'd0);
    o_pop = 1'b1;
    @(negedge clk);
    o_pop = 1'b0;
    chk("R6 pop err pulse", {62'd0, o_err, o_busy}, 64'd2);
    repeat (4) @(negedge clk);
    chk("R6 misaligned sp unchanged", o_sp, ODD_TOP);
    chk("R6 no memory access", 64'(o_req_count), 64'd0);
    chk("R6 no done", 64'(o_done_count), 64'd0);

    @(negedge clk);
    push_req = 1'b1; push_data = 64'h99;
    @(negedge clk);
    push_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 sp after mid-op reset", sp_out, TOP);
    chk("R1 idle after mid-op reset", {62'd0, busy, done}, 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule